// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. It has two divider schemes, and one control bit chooses between them. The power-of-two scheme divides by 2^N using a 4-bit exponent. The linear scheme divides by an even integer using an 8-bit value. The divider never divides by less than two, so the serial clock always has a 50% duty cycle. It toggles once per half period, and the half period is a whole number of module clocks.

While `run` is low, the block stays idle. It holds the serial clock at the idle level given by `cpol` and copies the divider setting into its own register. While `run` is high, that copy is frozen and the control input is ignored. The half-period counter starts from zero at each rising edge of `run`. Whenever the serial clock moves, the block pulses one of two one-cycle strobes in the same cycle, so that a shifter can launch and capture data:
- one strobe for the edge that leaves the idle level (leading);
- one strobe for the edge that returns to it (trailing).

Top module: `spi_sclk_gen`

## Requirements
- R1: During reset and in the first cycle after it, `sclk`, `lead_stb` and `trail_stb` are all low.
- R2: Bit 12 of `div_ctrl` selects the scheme. When it is 1, only bits 7:0 set the rate. When it is 0, only bits 11:8 set the rate.
- R3: In linear mode with value M in bits 7:0, `sclk` toggles every M+1 module clocks. This divides by 2*(M+1).
- R4: In power-of-two mode with N in bits 11:8 and N at least 1, `sclk` toggles every 2^(N-1) module clocks. This divides by 2^N.
- R5: In power-of-two mode, N = 0 gives division by 2, the same as N = 1.
- R6: After `run` rises, the first toggle of `sclk` is seen after H cycles with `run` high, where H is the half period. Each start reloads the counter, whatever state the previous run stopped in.
- R7: `lead_stb` is high for exactly the one cycle in which `sclk` first shows the level opposite to the idle level.
- R8: `trail_stb` is high for exactly the one cycle in which `sclk` first shows the idle level again after a leading edge.
- R9: One cycle after `run` is sampled low, `sclk` equals the `cpol` value sampled then, and both strobes are low.
- R10: Changes to `div_ctrl` while `run` is high do not change the rate of that run. The setting is captured only while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_ctrl | input | 13 | Bit 12 selects the scheme (1 = linear), bits 11:8 hold the exponent, bits 7:0 hold the linear value |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | High while a transfer is in progress |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse when `sclk` leaves the idle level |
| trail_stb | output | 1 | One-cycle pulse when `sclk` returns to the idle level |

## Verification
All outputs are registered, so every effect of an input sampled at a clock edge shows one settling delay after that edge. The idle level and the absence of strobes are due one edge after `run` is sampled low. The setting is captured two edges before a start, and the first toggle falls exactly on the H-th edge at which `run` is sampled high. The bench drives inputs at the falling edge and samples 1 ns after each rising edge. For every cycle of a run it compares `sclk` and both strobes with the values predicted from the cycle index and H. It then checks the idle result on the edge after `run` drops.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
    // Divider scheme chosen by the select bit of the control field.
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;
endpackage

// File: rtl/spi_div_ratio.sv
module spi_div_ratio #(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8,
    parameter int CNT_W = 15
) (
    input  logic [EXP_W+LIN_W:0] div_ctrl,
    output logic [CNT_W-1:0]     half_per
);
    import spi_div_pkg::*;

    localparam int SEL_BIT = EXP_W + LIN_W;

    div_mode_e         mode;
    logic [EXP_W-1:0]  exp_n;
    logic [LIN_W-1:0]  lin_m;

    always_comb begin
        mode  = div_mode_e'(div_ctrl[SEL_BIT]);
        exp_n = div_ctrl[LIN_W +: EXP_W];
        lin_m = div_ctrl[LIN_W-1:0];
        if (mode == DIV_LINEAR) begin
            half_per = CNT_W'(lin_m) + CNT_W'(1);
        end else if (exp_n == '0) begin
            half_per = CNT_W'(1);          // R5: exponent 0 behaves as divide-by-2
        end else begin
            half_per = CNT_W'(1) << (exp_n - EXP_W'(1));
        end
    end

    // R3/R4: a half period of zero would stall the counter
    always_comb begin
        a_r4_half_nonzero: assert (half_per != '0);
    end
endmodule

// File: rtl/spi_div_core.sv
module spi_div_core #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [CNT_W-1:0] half_in,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    typedef struct packed {
        logic             sclk;
        logic             lead;
        logic             trail;
        logic             idle_lvl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_edge;

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        at_edge    = (st_q.cnt == st_q.half - CNT_W'(1));
        if (!run) begin
            st_d.sclk     = cpol;
            st_d.idle_lvl = cpol;
            st_d.cnt      = '0;
            st_d.half     = half_in;
        end else if (at_edge) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            if (st_q.sclk == st_q.idle_lvl) begin
                st_d.lead = 1'b1;
            end else begin
                st_d.trail = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk: 1'b0, lead: 1'b0, trail: 1'b0, idle_lvl: 1'b0,
                      cnt: '0, half: CNT_W'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk      = st_q.sclk;
    assign lead_stb  = st_q.lead;
    assign trail_stb = st_q.trail;

    a_r7_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));
    a_r7_lead_moves_clk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != st_q.idle_lvl) && (sclk != $past(sclk)));
    a_r8_trail_moves_clk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == st_q.idle_lvl) && (sclk != $past(sclk)));
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);
    a_r10_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> $stable(st_q.half));
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.half);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EXP_W+LIN_W:0] div_ctrl,
    input  logic                 cpol,
    input  logic                 run,
    output logic                 sclk,
    output logic                 lead_stb,
    output logic                 trail_stb
);
    localparam int EXP_HALF_W = (1 << EXP_W) - 1;
    localparam int CNT_W = (EXP_HALF_W > LIN_W + 1) ? EXP_HALF_W : LIN_W + 1;

    logic [CNT_W-1:0] half_per;

    spi_div_ratio #(.EXP_W(EXP_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_ratio (
        .div_ctrl (div_ctrl),
        .half_per (half_per)
    );

    spi_div_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (cpol),
        .half_in   (half_per),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );
endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] div_ctrl = '0;
    logic        cpol = 1'b0;
    logic        run = 1'b0;
    logic        sclk, lead_stb, trail_stb;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_sclk_gen uut (
        .clk(clk), .rst_n(rst_n), .div_ctrl(div_ctrl), .cpol(cpol), .run(run),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    function automatic int half_of(input logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        if (c[11:8] == 4'd0) return 1;
        return 1 << (int'(c[11:8]) - 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // One run: setting captured while idle, run held for len cycles,
    // optional setting change halfway through (must be ignored).
    task automatic burst(input logic [12:0] c, input logic pol, input int len,
                         input logic [12:0] c_mid, input string tag);
        int h;
        @(negedge clk);
        div_ctrl = c; cpol = pol; run = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R9", {sclk, lead_stb, trail_stb}, {pol, 2'b00});
        @(negedge clk);
        run = 1'b1;
        h = half_of(c);
        for (int j = 1; j <= len; j++) begin
            int t;
            @(posedge clk); #1;
            t = j / h;
            chk(tag, sclk, pol ^ t[0]);
            chk("R7", lead_stb, (j % h == 0) && t[0]);
            chk("R8", trail_stb, (j % h == 0) && !t[0]);
            if (j == len / 2) div_ctrl = c_mid;
        end
        @(negedge clk);
        run = 1'b0;
        @(posedge clk); #1;
        chk("R9", {sclk, lead_stb, trail_stb}, {pol, 2'b00});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        #1 chk("R1", {sclk, lead_stb, trail_stb}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 chk("R1", {sclk, lead_stb, trail_stb}, 0);

        burst({1'b1, 4'd9, 8'd0},  1'b0, 12,  13'h0, "R3");  // divide by 2
        burst({1'b1, 4'd0, 8'd3},  1'b0, 40,  13'h0, "R3");
        burst({1'b1, 4'd0, 8'd255}, 1'b1, 1030, 13'h0, "R3");
        burst({1'b0, 4'd0, 8'd77}, 1'b0, 12,  13'h0, "R5");
        burst({1'b0, 4'd1, 8'd0},  1'b1, 12,  13'h0, "R4");
        burst({1'b0, 4'd3, 8'd0},  1'b0, 40,  13'h0, "R4");
        burst({1'b0, 4'd9, 8'd0},  1'b0, 1030, 13'h0, "R4");
        // same fields, only the select bit differs
        burst({1'b1, 4'd3, 8'd7},  1'b0, 40,  13'h0, "R2");
        burst({1'b0, 4'd3, 8'd7},  1'b0, 40,  13'h0, "R2");
        // stop mid half-period, then restart: counter must reload
        burst({1'b1, 4'd0, 8'd9},  1'b0, 15,  13'h0, "R6");
        burst({1'b1, 4'd0, 8'd9},  1'b1, 45,  13'h0, "R6");
        // setting changed while running must not alter the rate
        burst({1'b1, 4'd0, 8'd4},  1'b0, 60,  {1'b0, 4'd0, 8'd0}, "R10");
        burst({1'b0, 4'd2, 8'd0},  1'b1, 60,  {1'b1, 4'd0, 8'd20}, "R10");

        for (int k = 0; k < 30; k++) begin
            logic [12:0] c;
            int len;
            c = 13'($urandom);
            if (!c[12] && c[11:8] > 4'd9) c[11:8] = 4'($urandom_range(0, 9));
            len = 1 + int'($urandom_range(0, 3 * half_of(c) + 4));
            burst(c, 1'($urandom), len, 13'($urandom),
                  c[12] ? "R3" : (c[11:8] == 4'd0 ? "R5" : "R4"));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule